// File: doc/BRIEF.md
# Serial ADC Readout Sequencer

This block is the converter side of a three-wire serial read port. The host pulls an active-low select line, toggles a serial clock, and reads the previous conversion result on a data line that the block drives only while it is selected. The select line and the serial clock are asynchronous to the block. Both are synchronised onto the internal system clock, and the block acts on the serial clock's falling edges it detects there.

The block counts serial clock falling edges within a frame. The count decides when the result shifts out, most significant bit first. It also opens a sampling window for the analog front end and issues a one-cycle start pulse to the conversion controller on the tenth edge. After that edge the data line reads zero. The controller reports a finished conversion with a done strobe and the new result. A select that is held low across frames reloads the new result on that strobe, so its MSB appears without any select edge. Changes on the select line are accepted only after they have been stable for a programmable number of cycles.

Top module: `adc_serial_seq`

## Requirements
- R1: While the accepted select is high, `sdo_oe`, `sdo` and `sample_on` stay 0. Serial clock edges in that time do not shift the result: the next frame still starts with bit 9 of the held result.
- R2: An accepted select fall clears the edge count and raises `sdo_oe`. It drives `sdo` with bit 9 of the result held at that moment.
- R3: The result goes out MSB first. Bit 9 is on `sdo` before the first falling edge, bit 9-k after falling edge k, and bit 0 after the ninth.
- R4: From the tenth falling edge until the next reload, `sdo` is 0. Frames of 11 to 16 clocks therefore read zeros in the extra positions.
- R5: `sample_on` rises on the third falling edge of a frame and falls on the tenth. It also falls when the select is released.
- R6: `conv_start` is a single-cycle pulse issued on the tenth falling edge only. A frame of fewer than ten edges issues none.
- R7: With select still low after the tenth edge, a `conv_done` strobe loads `conv_result` and restarts the frame. `sdo` then shows bit 9 of the new result, and the next edges shift it out.
- R8: An accepted select rise drops `sdo_oe` and `sample_on` one cycle later, even in the middle of a frame.
- R9: A select level is accepted only after it has differed from the accepted level for FILT_CYC consecutive cycles (default 4). Shorter pulses have no effect.
- R10: `conv_result` is captured only in cycles where `conv_done` is 1. Its value in any other cycle has no effect on later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Asynchronous active-low select from the host |
| sclk | input | 1 | Asynchronous serial clock from the host |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Drive enable for the serial data pad |
| sample_on | output | 1 | Analog sampling window active |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_done | input | 1 | Conversion finished strobe |
| conv_result | input | RES_W | Result that goes with `conv_done` |

## Verification
Frames of 10, 16, 5 and 4 clocks run with select toggled between frames. This separates the shifted bits from the zero padding, and a cut-short frame from one that starts a conversion. A held-low select across two frames shows the automatic reload on the done strobe, and dropping select in the middle of a frame shows the window is cut off. A short select glitch and clock edges sent while deselected must leave the outputs and the held result unchanged. The result input carries new noise every cycle, so any capture outside a done strobe would change a later readout.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Accepted select level and the one-cycle marker of an accepted fall
    typedef struct packed {
        logic sel;
        logic start;
    } sel_t;

    // Frame phase: not selected, shifting result bits, zero padding
    typedef enum logic [1:0] {
        FR_OFF   = 2'd0,
        FR_SHIFT = 2'd1,
        FR_PAD   = 2'd2
    } frame_ph_e;

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_csfilt.sv
module adc_seq_csfilt
    import adc_seq_pkg::*;
#(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n_s,
    output sel_t sel_o
);
    localparam int RUN_W = cnt_width(FILT_CYC);

    logic             acc;
    logic [RUN_W-1:0] run;
    logic             start;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= 1'b1;
            run   <= '0;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            if (sel_n_s != acc) begin
                if (run == RUN_W'(FILT_CYC - 1)) begin
                    acc   <= sel_n_s;
                    run   <= '0;
                    start <= ~sel_n_s;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    assign sel_o.sel   = ~acc;
    assign sel_o.start = start;

    // R9
    filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc != $past(acc)) |-> ($past(run) == RUN_W'(FILT_CYC - 1)));

    // R2
    start_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> sel_o.sel);
endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int MAX_CLKS  = 16,
    parameter int SAMP_EDGE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  sel_t             selin,
    input  logic             sclk_s,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             sample_on,
    output logic             conv_start
);
    localparam int CNT_W     = cnt_width(MAX_CLKS);
    localparam int HOLD_EDGE = RES_W;

    frame_ph_e        phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic [RES_W-1:0] shreg;
    logic [RES_W-1:0] held;
    logic             sclk_d;
    logic             fall;
    logic             samp_q;
    logic             cst_q;

    assign fall = sclk_d & ~sclk_s;

    always_comb begin
        nxt = (cnt == CNT_W'(MAX_CLKS)) ? cnt : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= FR_OFF;
            cnt    <= '0;
            shreg  <= '0;
            held   <= '0;
            sclk_d <= 1'b0;
            samp_q <= 1'b0;
            cst_q  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            cst_q  <= 1'b0;
            if (conv_done) begin
                held <= conv_result;
            end
            if (selin.start) begin
                phase  <= FR_SHIFT;
                shreg  <= held;
                cnt    <= '0;
                samp_q <= 1'b0;
            end else if (!selin.sel) begin
                phase  <= FR_OFF;
                samp_q <= 1'b0;
            end else if (phase == FR_PAD && conv_done) begin
                phase <= FR_SHIFT;
                shreg <= conv_result;
                cnt   <= '0;
            end else if (phase != FR_OFF && fall) begin
                cnt <= nxt;
                if (nxt < CNT_W'(HOLD_EDGE)) begin
                    shreg <= {shreg[RES_W-2:0], 1'b0};
                end
                if (nxt == CNT_W'(SAMP_EDGE)) begin
                    samp_q <= 1'b1;
                end
                if (nxt == CNT_W'(HOLD_EDGE)) begin
                    samp_q <= 1'b0;
                    cst_q  <= 1'b1;
                    phase  <= FR_PAD;
                end
            end
        end
    end

    assign sdo        = (phase == FR_SHIFT) & shreg[RES_W-1];
    assign sdo_oe     = (phase != FR_OFF);
    assign sample_on  = samp_q;
    assign conv_start = cst_q;

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R6
    start_after_window_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(sample_on));

    // R5
    window_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_on) |-> (cnt == CNT_W'(SAMP_EDGE)));

    // R4
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !sdo);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !selin.sel |=> !sdo_oe);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sample_on);
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int MAX_CLKS    = 16,
    parameter int SAMP_EDGE   = 3,
    parameter int FILT_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             sclk,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             sample_on,
    output logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result
);
    logic sel_n_s;
    logic sclk_s;
    sel_t sel_acc;

    adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
        .clk (clk),
        .rst (rst),
        .d   (sel_n),
        .q   (sel_n_s)
    );

    adc_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk (clk),
        .rst (rst),
        .d   (sclk),
        .q   (sclk_s)
    );

    adc_seq_csfilt #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .sel_n_s (sel_n_s),
        .sel_o   (sel_acc)
    );

    adc_seq_frame #(
        .RES_W     (RES_W),
        .MAX_CLKS  (MAX_CLKS),
        .SAMP_EDGE (SAMP_EDGE)
    ) u_frame (
        .clk         (clk),
        .rst         (rst),
        .selin       (sel_acc),
        .sclk_s      (sclk_s),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .sample_on   (sample_on),
        .conv_start  (conv_start)
    );
endmodule

// File: tb/adc_serial_seq_tb.sv
module adc_serial_seq_tb;
    localparam int HALF = 6;
    localparam int FILT = 4;
    localparam int BUSY = 120;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdo, sdo_oe, sample_on, conv_start;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;

    int checks = 0;
    int errors = 0;
    bit mon_on = 0;
    int starts_seen = 0;
    int busy = 0;
    bit inj_req = 0;
    logic [9:0] inj_val = '0;
    logic [9:0] last_done = '0;

    always #5 clk = ~clk;

    adc_serial_seq u_dut (
        .clk (clk), .rst (rst), .sel_n (sel_n), .sclk (sclk),
        .sdo (sdo), .sdo_oe (sdo_oe), .sample_on (sample_on),
        .conv_start (conv_start), .conv_done (conv_done),
        .conv_result (conv_result)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    // Behavioural conversion controller; result input carries noise except on done
    always @(negedge clk) begin
        conv_done   = 1'b0;
        conv_result = 10'($urandom);
        if (busy > 0) begin
            busy--;
            if (busy == 0) begin
                conv_done = 1'b1;
                last_done = conv_result;
            end
        end
        if (conv_start) begin
            starts_seen++;
            busy = BUSY;
        end
        if (inj_req) begin
            inj_req     = 1'b0;
            conv_done   = 1'b1;
            conv_result = inj_val;
            last_done   = inj_val;
        end
    end

    // Cycle reference model
    bit         hc[$];
    bit         hi[$];
    bit         m_acc, m_start, m_act, m_pad, m_samp, m_cst;
    int         m_run, m_edges;
    logic [9:0] m_word, m_res;

    always @(posedge clk) begin
        bit cs_seen;
        bit fall;
        int e;
        if (rst) begin
            hc = '{1'b1, 1'b1, 1'b1};
            hi = '{1'b0, 1'b0, 1'b0, 1'b0};
            m_acc = 1; m_run = 0; m_start = 0; m_act = 0; m_pad = 0;
            m_samp = 0; m_cst = 0; m_edges = 0; m_word = '0; m_res = '0;
        end else begin
            hc.push_front(sel_n);
            cs_seen = hc[2];
            void'(hc.pop_back());
            hi.push_front(sclk);
            fall = hi[3] && !hi[2];
            void'(hi.pop_back());
            m_cst = 0;
            if (m_start) begin
                m_act = 1; m_pad = 0; m_word = m_res; m_edges = 0; m_samp = 0;
            end else if (m_acc) begin
                m_act = 0; m_samp = 0;
            end else if (m_pad && conv_done) begin
                m_pad = 0; m_word = conv_result; m_edges = 0;
            end else if (m_act && fall) begin
                e = (m_edges >= 16) ? 16 : m_edges + 1;
                m_edges = e;
                if (e < 10) m_word = m_word << 1;
                if (e == 3) m_samp = 1;
                if (e == 10) begin m_samp = 0; m_pad = 1; m_cst = 1; end
            end
            if (conv_done) m_res = conv_result;
            m_start = 0;
            if (cs_seen != m_acc) begin
                if (m_run == FILT - 1) begin
                    m_acc = cs_seen; m_run = 0; m_start = !cs_seen;
                end else begin
                    m_run++;
                end
            end else begin
                m_run = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            check(sdo_oe == m_act, "R8 oe", int'(sdo_oe), int'(m_act));
            check(sdo == (m_act && !m_pad && m_word[9]), "R3 sdo", int'(sdo),
                  int'(m_act && !m_pad && m_word[9]));
            check(sample_on == m_samp, "R5 sample_on", int'(sample_on), int'(m_samp));
            check(conv_start == m_cst, "R6 conv_start", int'(conv_start), int'(m_cst));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1; wait_cyc(HALF);
        sclk = 1'b0; wait_cyc(HALF);
    endtask

    task automatic run_frame(input int n, output logic [9:0] w);
        w = '0;
        w[9] = sdo;
        for (int k = 1; k <= n; k++) begin
            pulse_sclk();
            if (k <= 9) w[9-k] = sdo;
            else check(sdo == 1'b0, "R4 padding", int'(sdo), 0);
            check(sample_on == (k >= 3 && k < 10), "R5 window", int'(sample_on),
                  int'(k >= 3 && k < 10));
        end
    endtask

    task automatic select_on();
        sel_n = 1'b0; wait_cyc(FILT + 8);
    endtask

    task automatic select_off();
        sel_n = 1'b1; wait_cyc(FILT + 8);
    endtask

    initial begin
        logic [9:0] w, v1, v2, v3, v4;
        int s0;
        wait_cyc(5);
        check(sdo_oe == 0, "R1 reset oe", int'(sdo_oe), 0);
        check(sdo == 0, "R1 reset sdo", int'(sdo), 0);
        check(sample_on == 0, "R1 reset window", int'(sample_on), 0);
        check(conv_start == 0, "R6 reset start", int'(conv_start), 0);
        rst = 1'b0;
        mon_on = 1;
        wait_cyc(2);

        inj_val = 10'h2A5; inj_req = 1'b1;
        wait_cyc(4);
        select_on();
        check(sdo_oe == 1, "R2 oe after select", int'(sdo_oe), 1);
        check(sdo == 1, "R2 msb after select", int'(sdo), 1);
        run_frame(10, w);
        check(w == 10'h2A5, "R3 ten clock word", int'(w), 'h2A5);
        check(starts_seen == 1, "R6 one start", starts_seen, 1);
        select_off();
        check(sdo_oe == 0, "R8 release", int'(sdo_oe), 0);
        wait_cyc(BUSY + 20);
        v1 = last_done;

        sel_n = 1'b0; wait_cyc(FILT - 2); sel_n = 1'b1; wait_cyc(12);
        check(sdo_oe == 0, "R9 glitch ignored", int'(sdo_oe), 0);
        for (int p = 0; p < 3; p++) pulse_sclk();
        check(sdo_oe == 0, "R1 edges while idle oe", int'(sdo_oe), 0);
        check(sample_on == 0, "R1 edges while idle window", int'(sample_on), 0);

        select_on();
        run_frame(16, w);
        check(w == v1, "R1 R10 sixteen clock word", int'(w), int'(v1));
        select_off();
        wait_cyc(BUSY + 20);
        v2 = last_done;

        s0 = starts_seen;
        select_on();
        run_frame(5, w);
        check(w[9:5] == v2[9:5], "R3 short frame bits", int'(w[9:5]), int'(v2[9:5]));
        select_off();
        wait_cyc(BUSY + 20);
        check(starts_seen == s0, "R6 no start on short frame", starts_seen, s0);

        select_on();
        run_frame(10, w);
        check(w == v2, "R10 result unchanged", int'(w), int'(v2));
        wait_cyc(BUSY + 20);
        v3 = last_done;
        check(sdo_oe == 1, "R7 still driving", int'(sdo_oe), 1);
        check(sdo == v3[9], "R7 new msb", int'(sdo), int'(v3[9]));
        run_frame(10, w);
        check(w == v3, "R7 continuous word", int'(w), int'(v3));
        wait_cyc(BUSY + 20);
        v4 = last_done;
        run_frame(4, w);
        check(w[9:6] == v4[9:6], "R7 second reload bits", int'(w[9:6]), int'(v4[9:6]));
        sel_n = 1'b1; wait_cyc(12);
        check(sdo_oe == 0, "R8 mid frame release oe", int'(sdo_oe), 0);
        check(sample_on == 0, "R5 R8 mid frame window", int'(sample_on), 0);

        wait_cyc(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired got 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule